// File: doc/BRIEF.md
# DDR SDRAM Mode-Register Programming Sequencer

This block sits on the controller side of a DDR SDRAM interface. On a start request it writes two LOAD MODE REGISTER commands: first the extended register, which carries the DLL on/off bit and the output drive-strength bit, and then the base register, which carries the burst length and the CAS latency. Before each write it waits until the controller reports that every bank is idle. It also keeps the required minimum spacing (tMRD, given in clocks on an input) after each write.

Between commands the block drives NOP while a sequence runs and DESELECT when it is idle. A busy flag covers the whole sequence, including the last tMRD wait. A read-permitted flag rises only after a fixed settle interval has passed since the extended register was written with the DLL enabled. The controller uses this flag to hold back its first READ.

Top module: `ddr_mrs_seq`

## Requirements
- R1: After reset the command pins show DESELECT (CS# high), busy and read-permitted are low, and bank address and address bus are zero.
- R2: While busy is low the command pins show DESELECT. While busy is high, every cycle that is not a LOAD MODE REGISTER shows NOP (CS# low, RAS#, CAS# and WE# high).
- R3: A start request seen while idle raises busy in the next cycle. A start request seen while busy is ignored: the sequence and its timing are unchanged and exactly two register writes occur.
- R4: LOAD MODE REGISTER is encoded as CS#, RAS#, CAS# and WE# all low. It appears only in a cycle after one in which the bank-idle input was high, and it is otherwise held off with NOP. The first write appears two cycles after the start cycle when the banks are idle, and one cycle after bank-idle is first seen high otherwise.
- R5: Each accepted start produces exactly two writes. The first uses bank address 01 (extended register) and the second uses bank address 00 (base register).
- R6: The extended word has A0 = 1 when the DLL is to be disabled and A1 = 1 for reduced drive. A2 through A12 are zero.
- R7: The base word has A2:A0 = 010 (burst 4) for burst select 00 or 11, 001 (burst 2) for select 01, and 011 (burst 8) for select 10. A3 = 0. A6:A4 = 010 for CAS latency 2 and 110 for CAS latency 2.5. A12:A7 are zero.
- R8: The second write appears no earlier than tMRD clocks after the first, with tMRD = 0 treated as 1. It appears exactly then if the banks are idle, and otherwise one cycle after bank-idle returns.
- R9: Busy falls exactly tMRD clocks after the base-register write.
- R10: When the extended write enables the DLL, read-permitted rises exactly 200 clocks after that write. When the write disables the DLL, read-permitted stays low.
- R11: An accepted start clears read-permitted in the next cycle, and the settle count restarts from the new extended write.
- R12: The configuration inputs are captured when a start is accepted. Changes made later have no effect on the words written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to run the programming sequence |
| cfg_dll_off_i | input | 1 | 1 = write the DLL as disabled |
| cfg_drv_reduced_i | input | 1 | 1 = reduced output drive |
| cfg_cl_half_i | input | 1 | 0 = CAS latency 2, 1 = CAS latency 2.5 |
| cfg_burst_sel_i | input | 2 | Burst select: 00/11 = 4, 01 = 2, 10 = 8 |
| banks_idle_i | input | 1 | High when all banks are idle |
| tmrd_i | input | TMRD_W | Minimum clocks between a register write and the next command |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address / register select |
| addr_o | output | ADDR_W | Address bus carrying the register word |
| busy_o | output | 1 | Sequence in progress |
| read_ok_o | output | 1 | First READ permitted |

## Verification
The bench sweeps all 32 combinations of DLL, drive, CAS latency and burst select against tMRD values of 0, 1, 2 and 5. This separates each field position and encoding in both register words, and it separates the clamp of a zero spacing from true back-to-back issue. Bank-idle is held low for varying stretches before each write, some shorter and some longer than the tMRD wait. This tells whether the hold-off or the spacing counter governs the issue cycle. Every run flips the configuration right after the start and some runs add a second start mid-sequence, which shows whether the captured values and the ignore rule hold. A short run followed at once by a full run shows whether the settle interval restarts or carries over a stale count.

// File: rtl/ddr_mrs_pkg.sv
package ddr_mrs_pkg;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } ddr_cmd_t;

  localparam ddr_cmd_t CMD_DESEL = 4'b1111;
  localparam ddr_cmd_t CMD_NOP   = 4'b0111;
  localparam ddr_cmd_t CMD_LMR   = 4'b0000;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PEND_EXT,
    ST_PEND_BASE,
    ST_FINAL
  } seq_state_t;

  typedef struct packed {
    logic       dll_off;
    logic       drv_red;
    logic       cl_half;
    logic [1:0] burst_sel;
  } mrs_cfg_t;

endpackage

// File: rtl/ddr_mrs_words.sv
module ddr_mrs_words
  import ddr_mrs_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  mrs_cfg_t          cfg,
  output logic [ADDR_W-1:0] ext_word,
  output logic [ADDR_W-1:0] base_word
);

  always_comb begin
    ext_word    = '0;
    ext_word[0] = cfg.dll_off;
    ext_word[1] = cfg.drv_red;
  end

  always_comb begin
    base_word = '0;
    unique case (cfg.burst_sel)
      2'b01:   base_word[2:0] = 3'b001;
      2'b10:   base_word[2:0] = 3'b011;
      default: base_word[2:0] = 3'b010;
    endcase
    base_word[3]   = 1'b0;
    base_word[6:4] = cfg.cl_half ? 3'b110 : 3'b010;
  end

endmodule

// File: rtl/ddr_mrs_countdown.sv
module ddr_mrs_countdown #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/ddr_mrs_seq.sv
module ddr_mrs_seq
  import ddr_mrs_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int BA_W        = 2,
  parameter int TMRD_W      = 4,
  parameter int SETTLE_CLKS = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              cfg_dll_off_i,
  input  logic              cfg_drv_reduced_i,
  input  logic              cfg_cl_half_i,
  input  logic [1:0]        cfg_burst_sel_i,
  input  logic              banks_idle_i,
  input  logic [TMRD_W-1:0] tmrd_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              busy_o,
  output logic              read_ok_o
);

  localparam int SETTLE_W = $clog2(SETTLE_CLKS);
  localparam logic [SETTLE_W-1:0] SETTLE_LOAD = SETTLE_W'(SETTLE_CLKS - 1);
  localparam logic [BA_W-1:0] BA_EXT  = BA_W'(1);
  localparam logic [BA_W-1:0] BA_BASE = BA_W'(0);

  seq_state_t        state_q, state_d;
  mrs_cfg_t          cfg_q;
  ddr_cmd_t          cmd_q, cmd_d;
  logic [BA_W-1:0]   ba_q, ba_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              busy_q;
  logic              ok_q, run_q;

  logic [ADDR_W-1:0] ext_word, base_word;
  logic              gap_zero, settle_zero;
  logic              start_ok, pending, issue, emr_dll_on;
  logic [TMRD_W-1:0] tmrd_load, gap_val;

  assign start_ok   = (state_q == ST_IDLE) && start_i;
  assign pending    = (state_q == ST_PEND_EXT) || (state_q == ST_PEND_BASE);
  assign issue      = pending && banks_idle_i && gap_zero;
  assign emr_dll_on = issue && (state_q == ST_PEND_EXT) && !cfg_q.dll_off;
  assign tmrd_load  = (tmrd_i == '0) ? '0 : tmrd_i - TMRD_W'(1);
  assign gap_val    = issue ? tmrd_load : '0;

  ddr_mrs_words #(.ADDR_W(ADDR_W)) u_words (
    .cfg       (cfg_q),
    .ext_word  (ext_word),
    .base_word (base_word)
  );

  ddr_mrs_countdown #(.W(TMRD_W)) u_gap (
    .clk      (clk),
    .rst      (rst),
    .load     (issue || start_ok),
    .load_val (gap_val),
    .zero_o   (gap_zero)
  );

  ddr_mrs_countdown #(.W(SETTLE_W)) u_settle (
    .clk      (clk),
    .rst      (rst),
    .load     (emr_dll_on),
    .load_val (SETTLE_LOAD),
    .zero_o   (settle_zero)
  );

  always_comb begin
    state_d = state_q;
    cmd_d   = CMD_NOP;
    ba_d    = '0;
    addr_d  = '0;
    unique case (state_q)
      ST_IDLE: begin
        cmd_d = start_i ? CMD_NOP : CMD_DESEL;
        if (start_i) state_d = ST_PEND_EXT;
      end
      ST_PEND_EXT: begin
        if (issue) begin
          cmd_d   = CMD_LMR;
          ba_d    = BA_EXT;
          addr_d  = ext_word;
          state_d = ST_PEND_BASE;
        end
      end
      ST_PEND_BASE: begin
        if (issue) begin
          cmd_d   = CMD_LMR;
          ba_d    = BA_BASE;
          addr_d  = base_word;
          state_d = ST_FINAL;
        end
      end
      ST_FINAL: begin
        if (gap_zero) begin
          cmd_d   = CMD_DESEL;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cmd_q   <= CMD_DESEL;
      ba_q    <= '0;
      addr_q  <= '0;
      busy_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      ba_q    <= ba_d;
      addr_q  <= addr_d;
      busy_q  <= (state_d != ST_IDLE);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (start_ok) begin
      cfg_q <= '{dll_off:   cfg_dll_off_i,
                 drv_red:   cfg_drv_reduced_i,
                 cl_half:   cfg_cl_half_i,
                 burst_sel: cfg_burst_sel_i};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || start_ok) begin
      run_q <= 1'b0;
      ok_q  <= 1'b0;
    end else if (emr_dll_on) begin
      run_q <= 1'b1;
    end else if (run_q && settle_zero) begin
      run_q <= 1'b0;
      ok_q  <= 1'b1;
    end
  end

  assign cs_n_o    = cmd_q.cs_n;
  assign ras_n_o   = cmd_q.ras_n;
  assign cas_n_o   = cmd_q.cas_n;
  assign we_n_o    = cmd_q.we_n;
  assign ba_o      = ba_q;
  assign addr_o    = addr_q;
  assign busy_o    = busy_q;
  assign read_ok_o = ok_q;

endmodule

// File: rtl/ddr_mrs_seq_chk.sv
module ddr_mrs_seq_chk #(
  parameter int ADDR_W      = 13,
  parameter int BA_W        = 2,
  parameter int TMRD_W      = 4,
  parameter int SETTLE_CLKS = 200
) (
  input logic              clk,
  input logic              rst,
  input logic              banks_idle_i,
  input logic [TMRD_W-1:0] tmrd_i,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              busy,
  input logic              read_ok
);

  localparam int DW = $clog2(SETTLE_CLKS) + 2;
  localparam logic [TMRD_W:0] SINCE_MAX = '1;
  localparam logic [DW-1:0]   DLL_MAX   = '1;

  logic              lmr, nop;
  logic [TMRD_W:0]   since_q;
  logic [TMRD_W-1:0] need_q;
  logic [DW-1:0]     dll_q;

  assign lmr = !cs_n && !ras_n && !cas_n && !we_n;
  assign nop = !cs_n && ras_n && cas_n && we_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_q <= SINCE_MAX;
      need_q  <= '0;
    end else if (lmr) begin
      since_q <= (TMRD_W+1)'(1);
      need_q  <= (tmrd_i == '0) ? TMRD_W'(1) : tmrd_i;
    end else if (since_q != SINCE_MAX) begin
      since_q <= since_q + (TMRD_W+1)'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                      dll_q <= '0;
    else if (lmr && ba == BA_W'(1) && !addr[0])   dll_q <= DW'(1);
    else if (dll_q != '0 && dll_q != DLL_MAX)     dll_q <= dll_q + DW'(1);
  end

  // R4
  lmr_needs_idle_chk: assert property (@(posedge clk) disable iff (rst)
    lmr |-> $past(banks_idle_i));

  // R2
  desel_when_free_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> cs_n);

  // R2
  nop_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !lmr) |-> nop);

  // R5
  lmr_bank_chk: assert property (@(posedge clk) disable iff (rst)
    lmr |-> (ba == BA_W'(0) || ba == BA_W'(1)));

  // R6
  ext_reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (lmr && ba == BA_W'(1)) |-> (addr[ADDR_W-1:2] == '0));

  // R8
  tmrd_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    lmr |-> (since_q >= {1'b0, need_q}));

  // R9
  busy_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (since_q == {1'b0, need_q}));

  // R10
  settle_window_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(read_ok) |-> (dll_q == DW'(SETTLE_CLKS)));

endmodule

bind ddr_mrs_seq ddr_mrs_seq_chk #(
  .ADDR_W(ADDR_W), .BA_W(BA_W), .TMRD_W(TMRD_W), .SETTLE_CLKS(SETTLE_CLKS)
) u_ddr_mrs_seq_chk (
  .clk          (clk),
  .rst          (rst),
  .banks_idle_i (banks_idle_i),
  .tmrd_i       (tmrd_i),
  .cs_n         (cs_n_o),
  .ras_n        (ras_n_o),
  .cas_n        (cas_n_o),
  .we_n         (we_n_o),
  .ba           (ba_o),
  .addr         (addr_o),
  .busy         (busy_o),
  .read_ok      (read_ok_o)
);

// File: tb/test_ddr_mrs_seq.sv
module test_ddr_mrs_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        cfg_dll_off_i = 1'b0;
  logic        cfg_drv_reduced_i = 1'b0;
  logic        cfg_cl_half_i = 1'b0;
  logic [1:0]  cfg_burst_sel_i = 2'b00;
  logic        banks_idle_i = 1'b1;
  logic [3:0]  tmrd_i = 4'd2;
  logic        cs_n_o, ras_n_o, cas_n_o, we_n_o;
  logic [1:0]  ba_o;
  logic [12:0] addr_o;
  logic        busy_o, read_ok_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  ddr_mrs_seq i_ddr_mrs_seq (
    .clk (clk), .rst (rst), .start_i (start_i),
    .cfg_dll_off_i (cfg_dll_off_i), .cfg_drv_reduced_i (cfg_drv_reduced_i),
    .cfg_cl_half_i (cfg_cl_half_i), .cfg_burst_sel_i (cfg_burst_sel_i),
    .banks_idle_i (banks_idle_i), .tmrd_i (tmrd_i),
    .cs_n_o (cs_n_o), .ras_n_o (ras_n_o), .cas_n_o (cas_n_o), .we_n_o (we_n_o),
    .ba_o (ba_o), .addr_o (addr_o), .busy_o (busy_o), .read_ok_o (read_ok_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic run_seq(input bit dll_off, input bit drv, input bit clh,
                         input logic [1:0] bsel, input logic [3:0] tmrd,
                         input int d, input int d2, input bit full, input bit poke);
    int teff, exp_ext, exp_base, blc, nl, e, b, fall, rok, pat_err, busy1, ok1;
    int ba1, ad1, ba2, ad2, n;
    bit lmr, nop, des;
    teff = (tmrd == 0) ? 1 : int'(tmrd);
    exp_ext = int'(drv) * 2 + int'(dll_off);
    blc = (bsel == 2'b01) ? 1 : (bsel == 2'b10) ? 3 : 2;
    exp_base = blc + (clh ? 6 : 2) * 16;
    nl = 0; e = -1; b = -1; fall = -1; rok = -1; pat_err = 0;
    busy1 = 0; ok1 = 1; ba1 = -1; ad1 = -1; ba2 = -1; ad2 = -1;
    tmrd_i = tmrd;
    cfg_dll_off_i = dll_off; cfg_drv_reduced_i = drv;
    cfg_cl_half_i = clh; cfg_burst_sel_i = bsel;
    start_i = 1'b1;
    banks_idle_i = (d == 0);
    n = 0;
    while (n < 3000) begin
      @(negedge clk);
      n++;
      lmr = ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0000);
      nop = ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0111);
      des = cs_n_o;
      if (n == 1) begin busy1 = busy_o; ok1 = read_ok_o; end
      if (busy_o ? !(lmr || nop) : !des) pat_err++;
      if (lmr) begin
        nl++;
        if (nl == 1) begin e = n; ba1 = ba_o; ad1 = addr_o; end
        if (nl == 2) begin b = n; ba2 = ba_o; ad2 = addr_o; end
      end
      if (!busy_o && fall < 0) fall = n;
      if (read_ok_o && rok < 0) rok = n;
      // inputs for cycle n
      start_i = (poke && n == 3);
      if (n == 1) begin
        cfg_dll_off_i = ~dll_off; cfg_drv_reduced_i = ~drv;
        cfg_cl_half_i = ~clh; cfg_burst_sel_i = ~bsel;
      end
      if (nl == 0)      banks_idle_i = (n > d);
      else if (nl == 1) banks_idle_i = (n >= e + d2);
      else              banks_idle_i = 1'b1;
      if (fall >= 0 && (!full || (e >= 0 && n >= e + 203))) break;
    end
    chk("R3 busy after start", busy1, 1);
    chk("R11 read_ok cleared by start", ok1, 0);
    chk("R5 write count", nl, 2);
    chk("R4 first write cycle", e, d + 2);
    chk("R5 ext bank", ba1, 1);
    chk("R6 ext word", ad1, exp_ext);
    chk("R8 second write cycle", b, ((e + teff - 1 > e + d2) ? e + teff - 1 : e + d2) + 1);
    chk("R5 base bank", ba2, 0);
    chk("R7 R12 base word", ad2, exp_base);
    chk("R9 busy fall cycle", fall, b + teff);
    chk("R2 idle/nop pattern errors", pat_err, 0);
    if (!full)        chk("R11 read_ok low in short run", rok, -1);
    else if (dll_off) chk("R10 read_ok stays low with DLL off", rok, -1);
    else              chk("R10 read_ok rise cycle", rok, e + 200);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 cs_n after reset", cs_n_o, 1);
    chk("R1 busy after reset", busy_o, 0);
    chk("R1 read_ok after reset", read_ok_o, 0);
    chk("R1 addr after reset", addr_o, 0);
    chk("R1 ba after reset", ba_o, 0);
    for (int ci = 0; ci < 32; ci++) begin
      for (int ti = 0; ti < 4; ti++) begin
        logic [3:0] tm;
        tm = (ti == 0) ? 4'd0 : (ti == 1) ? 4'd1 : (ti == 2) ? 4'd2 : 4'd5;
        run_seq(ci[0], ci[1], ci[2], ci[4:3], tm, (ci + ti) % 3,
                (ci * ti + ti) % 5, 1'b1, (ci % 4 == 0));
      end
    end
    // R11 restart: short DLL-on run, then an immediate full run
    run_seq(1'b0, 1'b0, 1'b0, 2'b00, 4'd2, 0, 0, 1'b0, 1'b0);
    run_seq(1'b0, 1'b1, 1'b1, 2'b00, 4'd3, 2, 4, 1'b1, 1'b0);
    @(negedge clk);
    chk("R2 deselect after sequence", cs_n_o, 1);
    report();
  end

endmodule